// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block sequences the conversions of a multi-channel analog-to-digital converter. Software writes a small configuration word (channel number, a two-bit mode, a start bit and a wait-for-read enable) through a one-cycle write strobe. The block then issues one launch pulse per conversion together with the channel to convert, and it waits for the converter's done pulse and result. Each result is packed with its channel number into a data register. Each finished conversion pulses a completion request, and a result that replaces an unread one pulses an overrun request.

Two mode bits select the sequence. Bit 1 chooses between a single channel and a downward scan that ends at channel 0. Bit 0 chooses between one pass and repeating passes. Configuration written while a sequence runs is not applied at once. A new mode applies after the conversion in flight. A new channel or start applies after a single-channel conversion, or only after a scan has reached channel 0. With wait-for-read set, the sequencer parks the second unread result and issues no further launch until software reads the data register.

Top module: `adc_seq_top`

## Requirements
- R1: A write with the start bit set while the block is idle produces, one cycle later, a single-cycle `convStart` with `convChan` equal to the written channel. Mode encoding: 00 single channel once, 01 single channel repeating, 10 scan once, 11 scan repeating.
- R2: In a scan mode, each conversion after the first launches the channel one below the previous one. The pass ends after channel 0.
- R3: A mode written during a conversion takes effect only after that conversion. If a single-channel conversion of channel n > 0 is running and the mode is changed to a scan mode without a start bit, channels n-1 down to 0 are converted next, and the channel written with that change is not used.
- R4: A channel and start bit written during a single-channel conversion are used for the next conversion. Written during a scan, they are used only after the scan has converted channel 0.
- R5: Repeating modes start a new pass at each pass end while the start bit is set. Writing the start bit as 0 ends the sequence at the next pass end. The once modes stop after one pass.
- R6: `busy` is 0 after reset and while idle. It is 1 from the cycle after an accepted start until the sequence ends.
- R7: `dataOut` holds the 10-bit result in bits 9:0, zeros in bits 11:10 and the converted channel in bits 15:12. It is 0 after reset.
- R8: Every finished conversion produces exactly one `cmpReq` pulse, one cycle after `convDone`.
- R9: With wait-for-read clear, a result written while the data register holds an unread result pulses `ovrReq` together with `cmpReq`. A `dataRd` in the same cycle as `convDone` counts as a read, and no overrun is flagged.
- R10: With wait-for-read set, a second unread result is parked. No `convStart` follows until `dataRd`, which moves the parked result into `dataOut`. `ovrReq` never pulses.
- R11: A start bit written together with a new mode and channel during a conversion starts the new mode from the newly written channel at the next boundary. This takes precedence over the implied continuation of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | One-cycle write strobe for the configuration fields |
| cfgMode | input | 2 | Mode field |
| cfgChan | input | 4 | Channel field |
| cfgStart | input | 1 | Start bit |
| cfgWaitRd | input | 1 | Wait-for-read enable |
| dataRd | input | 1 | Data register read strobe |
| convDone | input | 1 | Converter done pulse |
| convResult | input | 10 | Converter result, valid with convDone |
| busy | output | 1 | Sequence active |
| convStart | output | 1 | Launch pulse to converter |
| convChan | output | 4 | Channel for the launched conversion |
| dataOut | output | 16 | Data register |
| cmpReq | output | 1 | Conversion-complete request pulse |
| ovrReq | output | 1 | Overrun error request pulse |

## Verification
Two kinds of events can fall into one clock cycle. The first is a result arriving while the data register is being read. To provoke it, the bench holds `dataRd` high through a repeating single-channel run, so that every `convDone` meets a read. A cycle-accurate model and a count of zero overrun pulses judge the outcome. The second is a configuration write landing while a conversion ends. The bench drives writes with and without the start bit during single-channel and scan conversions. It judges them by comparing the logged order of launched channels with the order the requirements predict, alongside the per-cycle model comparison.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam logic [1:0] MODE_FIX_ONE  = 2'b00;
  localparam logic [1:0] MODE_FIX_RUN  = 2'b01;
  localparam logic [1:0] MODE_SCAN_ONE = 2'b10;
  localparam logic [1:0] MODE_SCAN_RUN = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_STALL
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capData;  // write fresh result into data register
    logic capHold;  // park fresh result in hold register
    logic relHold;  // move parked result into data register
  } seqStb_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [1:0]        cfgMode,
  input  logic [CHAN_W-1:0] cfgChan,
  input  logic              cfgStart,
  input  logic              cfgWaitRd,
  input  logic              convDone,
  input  logic              dataRd,
  input  logic              dataFull,
  output logic              busy,
  output logic              convStart,
  output logic [CHAN_W-1:0] convChan,
  output seqStb_t           stb
);

  seqState_t         state;
  logic [1:0]        actMode;
  logic [CHAN_W-1:0] actChan;
  logic [1:0]        regMode;
  logic [CHAN_W-1:0] regChan;
  logic              regStart;
  logic              regWaitRd;
  logic              pendStart;

  logic              scanNow, atEnd, goNext, takePend;
  logic [CHAN_W-1:0] nxtChan;
  logic              stallNow, resultIn, decideNow;

  assign scanNow = actMode[1];
  assign atEnd   = !scanNow || (actChan == '0);

  // boundary decision: what follows the conversion that just finished
  always_comb begin
    goNext   = 1'b0;
    takePend = 1'b0;
    nxtChan  = actChan;
    if (!atEnd) begin
      goNext  = 1'b1;
      nxtChan = actChan - 1'b1;
    end else if (!scanNow && regMode[1] && (actChan != '0) && !pendStart) begin
      goNext  = 1'b1;
      nxtChan = actChan - 1'b1;
    end else if (pendStart) begin
      goNext   = 1'b1;
      takePend = 1'b1;
      nxtChan  = regChan;
    end else if (regMode[0] && regStart) begin
      goNext  = 1'b1;
      nxtChan = regChan;
    end
  end

  assign stallNow    = regWaitRd && dataFull && !dataRd;
  assign resultIn    = (state == ST_WAIT) && convDone;
  assign stb.capData = resultIn && !stallNow;
  assign stb.capHold = resultIn && stallNow;
  assign stb.relHold = (state == ST_STALL) && dataRd;
  assign decideNow   = stb.capData || stb.relHold;

  assign busy      = (state != ST_IDLE);
  assign convStart = (state == ST_LAUNCH);
  assign convChan  = actChan;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      actMode   <= MODE_FIX_ONE;
      actChan   <= '0;
      regMode   <= MODE_FIX_ONE;
      regChan   <= '0;
      regStart  <= 1'b0;
      regWaitRd <= 1'b0;
      pendStart <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cfgWr && cfgStart) begin
            actMode <= cfgMode;
            actChan <= cfgChan;
            state   <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: state <= ST_WAIT;
        ST_WAIT: begin
          if (stb.capHold) state <= ST_STALL;
        end
        ST_STALL: ;
        default: state <= ST_IDLE;
      endcase

      if (decideNow) begin
        if (goNext) begin
          actMode <= regMode;
          actChan <= nxtChan;
          state   <= ST_LAUNCH;
        end else begin
          state <= ST_IDLE;
        end
      end

      // register writes win over boundary clears
      if (cfgWr) begin
        regMode   <= cfgMode;
        regChan   <= cfgChan;
        regWaitRd <= cfgWaitRd;
        regStart  <= cfgStart;
      end else if (decideNow && !goNext) begin
        regStart  <= 1'b0;
      end

      if (cfgWr && busy)             pendStart <= cfgStart;
      else if (decideNow && takePend) pendStart <= 1'b0;
    end
  end

  a_r1_start_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  a_r6_busy_covers_launch: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> busy);

  a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STALL && !dataRd) |=> (state == ST_STALL && !convStart));

  a_r2_scan_step_down: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LAUNCH && $past(state) == ST_WAIT && $past(actMode[1]) &&
     $past(actChan) != '0) |-> (actChan == $past(actChan) - 1'b1));

endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 4,
  parameter int RES_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStb_t           stb,
  input  logic [CHAN_W-1:0] tagChan,
  input  logic [RES_W-1:0]  convResult,
  input  logic              dataRd,
  output logic              dataFull,
  output logic [DATA_W-1:0] dataOut,
  output logic              cmpReq,
  output logic              ovrReq
);

  localparam int PAD_W = DATA_W - CHAN_W - RES_W;

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] packed_w;

  generate
    if (PAD_W > 0) begin : g_pad
      assign packed_w = {tagChan, {PAD_W{1'b0}}, convResult};
    end else begin : g_nopad
      assign packed_w = {tagChan, convResult};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut  <= '0;
      holdReg  <= '0;
      dataFull <= 1'b0;
      cmpReq   <= 1'b0;
      ovrReq   <= 1'b0;
    end else begin
      cmpReq <= stb.capData || stb.capHold;
      ovrReq <= stb.capData && dataFull && !dataRd;
      if (stb.capData)      dataOut <= packed_w;
      else if (stb.relHold) dataOut <= holdReg;
      if (stb.capHold) holdReg <= packed_w;
      if (stb.capData || stb.relHold) dataFull <= 1'b1;
      else if (dataRd)                dataFull <= 1'b0;
    end
  end

  a_r9_overrun_with_complete: assert property (@(posedge clk) disable iff (!rstN)
    ovrReq |-> cmpReq);

  a_r8_complete_leaves_full: assert property (@(posedge clk) disable iff (!rstN)
    cmpReq |-> dataFull);

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 4,
  parameter int RES_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [1:0]        cfgMode,
  input  logic [CHAN_W-1:0] cfgChan,
  input  logic              cfgStart,
  input  logic              cfgWaitRd,
  input  logic              dataRd,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convResult,
  output logic              busy,
  output logic              convStart,
  output logic [CHAN_W-1:0] convChan,
  output logic [DATA_W-1:0] dataOut,
  output logic              cmpReq,
  output logic              ovrReq
);

  seqStb_t stb;
  logic    dataFull;

  adc_seq_ctrl #(.CHAN_W(CHAN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgMode(cfgMode), .cfgChan(cfgChan),
    .cfgStart(cfgStart), .cfgWaitRd(cfgWaitRd), .convDone(convDone),
    .dataRd(dataRd), .dataFull(dataFull), .busy(busy), .convStart(convStart),
    .convChan(convChan), .stb(stb)
  );

  adc_seq_dpath #(.CHAN_W(CHAN_W), .RES_W(RES_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .tagChan(convChan), .convResult(convResult),
    .dataRd(dataRd), .dataFull(dataFull), .dataOut(dataOut), .cmpReq(cmpReq),
    .ovrReq(ovrReq)
  );

endmodule

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;

  localparam int LAT = 4;

  logic clk = 0;
  logic rstN = 0;
  logic cfgWr = 0;
  logic [1:0] cfgMode = 0;
  logic [3:0] cfgChan = 0;
  logic cfgStart = 0;
  logic cfgWaitRd = 0;
  logic dataRd = 0;
  logic convDone = 0;
  logic [9:0] convResult = 0;
  logic busy, convStart, cmpReq, ovrReq;
  logic [3:0] convChan;
  logic [15:0] dataOut;

  always #10 clk = ~clk;

  adc_seq_top u_dut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgMode(cfgMode), .cfgChan(cfgChan),
    .cfgStart(cfgStart), .cfgWaitRd(cfgWaitRd), .dataRd(dataRd), .convDone(convDone),
    .convResult(convResult), .busy(busy), .convStart(convStart), .convChan(convChan),
    .dataOut(dataOut), .cmpReq(cmpReq), .ovrReq(ovrReq)
  );

  int nComp = 0, nFail = 0, cycles = 0;
  int ovrCount = 0, cmpCount = 0;
  int pendCnt = 0, seqN = 0;
  logic [9:0] lastRes = 0;
  int launched[$];
  int expQ[$];
  bit modelOn = 0;

  // behavioural reference: 0 idle, 1 launch, 2 waiting, 3 parked
  int mState = 0, mActMode = 0, mActChan = 0, mRegMode = 0, mRegChan = 0;
  bit mRegStart = 0, mRegWait = 0, mPend = 0, mFull = 0, mCmp = 0, mOvr = 0;
  logic [15:0] mData = 0, mHold = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mActMode = 0; mActChan = 0; mRegMode = 0; mRegChan = 0;
      mRegStart = 0; mRegWait = 0; mPend = 0; mFull = 0; mCmp = 0; mOvr = 0;
      mData = 0; mHold = 0;
    end else begin
      int st; int am; int ac; bit fullN; bit stRegClr; bit pendClr; bit decide;
      st = mState; am = mActMode; ac = mActChan;
      fullN = mFull && !dataRd; stRegClr = 0; pendClr = 0; decide = 0;
      mCmp = 0; mOvr = 0;
      if (mState == 0 && cfgWr && cfgStart) begin am = cfgMode; ac = cfgChan; st = 1; end
      else if (mState == 1) st = 2;
      else if (mState == 2 && convDone) begin
        mCmp = 1;
        if (mRegWait && mFull && !dataRd) begin
          mHold = {mActChan[3:0], 2'b00, convResult}; st = 3;
        end else begin
          mOvr = mFull && !dataRd;
          mData = {mActChan[3:0], 2'b00, convResult}; fullN = 1; decide = 1;
        end
      end else if (mState == 3 && dataRd) begin
        mData = mHold; fullN = 1; decide = 1;
      end
      if (decide) begin
        bit isScan; isScan = (mActMode >= 2);
        if (isScan && mActChan > 0) begin am = mRegMode; ac = mActChan - 1; st = 1; end
        else if (!isScan && mRegMode >= 2 && mActChan > 0 && !mPend) begin
          am = mRegMode; ac = mActChan - 1; st = 1;
        end else if (mPend) begin am = mRegMode; ac = mRegChan; st = 1; pendClr = 1; end
        else if ((mRegMode % 2) == 1 && mRegStart) begin am = mRegMode; ac = mRegChan; st = 1; end
        else begin st = 0; stRegClr = 1; end
      end
      if (cfgWr && mState != 0) mPend = cfgStart;
      else if (pendClr) mPend = 0;
      if (cfgWr) begin
        mRegMode = cfgMode; mRegChan = cfgChan; mRegWait = cfgWaitRd; mRegStart = cfgStart;
      end else if (stRegClr) mRegStart = 0;
      mState = st; mActMode = am; mActChan = ac; mFull = fullN;
    end
  end

  task automatic cmp1(string req, string what, int act, int exp);
    nComp++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // converter stub, launch log and per-cycle comparison, all at falling edge
  always @(negedge clk) begin
    cycles++;
    convDone = 0;
    if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) begin
        seqN++;
        convDone = 1;
        convResult = 10'((seqN * 7 + 41 * int'(convChan)) % 1024);
        lastRes = convResult;
      end
    end
    if (convStart) begin
      pendCnt = LAT;
      launched.push_back(int'(convChan));
    end
    if (ovrReq) ovrCount++;
    if (cmpReq) cmpCount++;
    if (modelOn) begin
      cmp1("R6", "busy", busy, mState != 0);
      cmp1("R1", "convStart", convStart, mState == 1);
      if (mState == 1) cmp1("R2", "convChan", convChan, mActChan);
      cmp1("R7", "dataOut", dataOut, mData);
      cmp1("R8", "cmpReq", cmpReq, mCmp);
      cmp1("R9", "ovrReq", ovrReq, mOvr);
    end
  end

  always @(negedge clk) begin
    if (cycles > 100000) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nComp, nFail);
      $finish;
    end
  end

  task automatic wr(input int mode, input int chan, input bit start, input bit waitR);
    cfgWr = 1; cfgMode = 2'(mode); cfgChan = 4'(chan); cfgStart = start; cfgWaitRd = waitR;
    @(negedge clk);
    cfgWr = 0; cfgStart = 0;
  endtask

  task automatic rdPulse();
    dataRd = 1; @(negedge clk); dataRd = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic checkSeq(string req);
    cmp1(req, "launch count", launched.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < launched.size(); i++)
      cmp1(req, "launch order", launched[i], expQ[i]);
    launched.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state (R6, R7)
    cmp1("R6", "busy after reset", busy, 0);
    cmp1("R7", "dataOut after reset", dataOut, 0);
    cmp1("R1", "no launch after reset", convStart, 0);
    modelOn = 1;

    // R1 fixed channel once, R7 packing
    wr(0, 5, 1, 0);
    cmp1("R6", "busy after start", busy, 1);
    cmp1("R1", "launch one cycle after write", convStart, 1);
    waitIdle();
    expQ = '{5}; checkSeq("R1");
    cmp1("R7", "packed result", dataOut, {4'd5, 2'b00, lastRes});
    cmp1("R6", "idle after single", busy, 0);

    // R2 scan once from 3, unread data: each result overruns (R9)
    ovrCount = 0; cmpCount = 0;
    wr(2, 3, 1, 0);
    waitIdle();
    expQ = '{3, 2, 1, 0}; checkSeq("R2");
    cmp1("R9", "overrun pulses", ovrCount, 4);
    cmp1("R8", "complete pulses", cmpCount, 4);

    // R10 wait-for-read: park second result
    wr(0, 0, 0, 1);
    rdPulse();
    ovrCount = 0;
    wr(2, 3, 1, 1);
    repeat (30) @(negedge clk);
    expQ = '{3, 2};
    cmp1("R10", "launches before read", launched.size(), 2);
    cmp1("R10", "busy while parked", busy, 1);
    for (int k = 0; k < 20 && busy; k++) begin
      rdPulse();
      repeat (8) @(negedge clk);
    end
    waitIdle();
    expQ = '{3, 2, 1, 0}; checkSeq("R10");
    cmp1("R10", "no overrun with wait", ovrCount, 0);

    // R5 repeating fixed channel with read colliding on every result (R9)
    ovrCount = 0; cmpCount = 0;
    dataRd = 1;
    wr(1, 7, 1, 0);
    repeat (30) @(negedge clk);
    wr(1, 7, 0, 0);
    waitIdle();
    dataRd = 0;
    cmp1("R9", "no overrun when read collides", ovrCount, 0);
    cmp1("R5", "repeats at least 3", (launched.size() >= 3), 1);
    foreach (launched[i]) cmp1("R5", "repeat channel", launched[i], 7);
    launched.delete();
    cmp1("R5", "stopped after start cleared", busy, 0);

    // R3 mode changed to scan during fixed conversion, no start: 3..0 follow
    wr(0, 4, 1, 0);
    wr(2, 9, 0, 0);
    waitIdle();
    expQ = '{4, 3, 2, 1, 0}; checkSeq("R3");

    // R4 new channel with start during scan waits for channel 0
    wr(2, 2, 1, 0);
    repeat (3) @(negedge clk);
    wr(2, 5, 1, 0);
    waitIdle();
    expQ = '{2, 1, 0, 5, 4, 3, 2, 1, 0}; checkSeq("R4");

    // R11 start with mode change during fixed conversion uses new channel
    wr(0, 6, 1, 0);
    repeat (2) @(negedge clk);
    wr(2, 3, 1, 0);
    waitIdle();
    expQ = '{6, 3, 2, 1, 0}; checkSeq("R11");

    // R4 fixed: new channel applied right after current conversion
    wr(1, 1, 1, 0);
    repeat (2) @(negedge clk);
    wr(1, 8, 1, 0);
    repeat (20) @(negedge clk);
    wr(1, 8, 0, 0);
    waitIdle();
    cmp1("R4", "first channel", launched.size() > 0 ? launched[0] : -1, 1);
    cmp1("R4", "second channel", launched.size() > 1 ? launched[1] : -1, 8);
    launched.delete();
    cmp1("R6", "idle at end", busy, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nComp, nFail);
    $finish;
  end

endmodule